// File: doc/BRIEF.md
# Static three-and-a-half digit LCD segment driver

This block drives a non-multiplexed liquid crystal panel that shows three full seven-segment digits, a leading half digit that can only show "1", and a minus sign. Every segment has its own output line, and all segments share one backplane line. The block produces the backplane as a symmetric square wave from the system clock. Each segment line carries the same square wave: it is inverted when the segment is lit and left in phase when the segment is dark. Over each full backplane period a segment therefore spends as long high as low, and the panel never sees a steady voltage.

A converter or other producer presents a binary reading of 0 to 1999, a negative flag and an overrange flag, and pulses a result strobe. The block keeps the values from the strobe and puts them on the panel only when the next backplane period starts. A lamp-test input overrides the data and drives every segment line to a constant high level, so the panel reads -1888. The backplane keeps running during lamp test.

Top module: `lcd_static_drv`

## Requirements
- R1: `backplane` is low after reset and changes level after every HALF_PERIOD (default 100) clock cycles, so one full period is 2*HALF_PERIOD cycles.
- R2: Outside lamp test, each segment line equals `backplane` when its segment is dark and the inverse of `backplane` when it is lit.
- R3: Outside lamp test, when `backplane` rises in the middle of a period, every segment line inverts on the same cycle. A segment line changes on no other cycle, except when the frame content changes at the falling edge of `backplane`.
- R4: Full digit k (k = 0 for units, 1 for tens, 2 for hundreds) drives `segOut[7k+6:7k]`, with bit 0 as segment a through bit 6 as segment g. Its lit pattern for decimal digit value 0..9 (g..a, hex) is 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F. Leading zeros are shown.
- R5: Both bits of `halfSeg` are lit together when the shown reading is 1000 or more, or when the shown result is overrange. Otherwise both are dark.
- R6: A result is treated as overrange when its overrange flag is set or its reading is above 1999. In that case all three full digits are dark and the half digit is lit.
- R7: `minusSeg` is lit exactly when the shown result has its negative flag set. This also holds for an overrange result.
- R8: While `lampTest` is high, every line of `segOut`, `halfSeg` and `minusSeg` is held at constant 1, whatever the data. `backplane` keeps toggling.
- R9: A reading, negative flag and overrange flag are captured on a `resultValid` cycle. They reach the panel at the next falling edge of `backplane`, which is the start of a period. A later strobe before that edge replaces the earlier one. A strobe on the same cycle as the edge is held for the following period.
- R10: After reset, the shown result is reading 0, positive and in range, so the panel shows "000" with the half digit and the minus sign dark.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| resultValid | input | 1 | One-cycle strobe that a new result is present |
| readingIn | input | READ_W (11) | Binary magnitude of the result |
| negIn | input | 1 | Result is negative |
| overIn | input | 1 | Result is out of range |
| lampTest | input | 1 | Force all segments on |
| backplane | output | 1 | Common backplane square wave |
| segOut | output | 7*NUM_DIG (21) | Full-digit segment lines, units digit lowest |
| halfSeg | output | 2 | The two segments of the leading "1" |
| minusSeg | output | 1 | Minus-sign segment |

## Verification
The bench compares every output on every cycle against a behavioural model. It places strobes to hit the frame edge: two strobes inside one period, where a design that copied data straight through would show the first value for part of a period, and a strobe on the exact cycle of the falling edge, where a wrong priority would drop the value or show it early. Readings 999, 1000, 1999 and 2047 probe the half-digit threshold and the implicit overrange. A wrong comparison there would light or drop the "1", or leave digits lit when they should be dark. Lamp test is checked together with a negative overrange value, because a design that only forced the data path would still blank the digits or leave the lines toggling.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  typedef struct packed {
    logic bpFlip;      // backplane changes level on this cycle
    logic frameStart;  // backplane falls: a new period begins next cycle
  } lcdStrobe_t;

  // Seven-segment pattern, bit 0 = segment a ... bit 6 = segment g.
  function automatic logic [6:0] segPattern(input logic [3:0] digitVal);
    logic [6:0] pat;
    case (digitVal)
      4'd0: pat = 7'h3F;
      4'd1: pat = 7'h06;
      4'd2: pat = 7'h5B;
      4'd3: pat = 7'h4F;
      4'd4: pat = 7'h66;
      4'd5: pat = 7'h6D;
      4'd6: pat = 7'h7D;
      4'd7: pat = 7'h07;
      4'd8: pat = 7'h7F;
      4'd9: pat = 7'h6F;
      default: pat = 7'h00;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/lcd_bp_ctrl.sv
module lcd_bp_ctrl
  import lcd_pkg::*;
#(
  parameter int HALF_PERIOD = 100
) (
  input  logic       clk,
  input  logic       rstN,
  output logic       backplane,
  output lcdStrobe_t strobe
);

  localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);

  logic [CNT_W-1:0] divCnt;
  logic             atLast;

  assign atLast = (divCnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt    <= '0;
      backplane <= 1'b0;
    end else if (atLast) begin
      divCnt    <= '0;
      backplane <= ~backplane;
    end else begin
      divCnt    <= divCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.bpFlip     = atLast;
    strobe.frameStart = atLast & backplane;
  end

endmodule

// File: rtl/lcd_seg_path.sv
module lcd_seg_path
  import lcd_pkg::*;
#(
  parameter int READ_W      = 11,
  parameter int NUM_DIG     = 3,
  parameter int MAX_READING = 1999
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lcdStrobe_t           strobe,
  input  logic                 backplane,
  input  logic                 resultValid,
  input  logic [READ_W-1:0]    readingIn,
  input  logic                 negIn,
  input  logic                 overIn,
  input  logic                 lampTest,
  output logic [7*NUM_DIG-1:0] segOut,
  output logic [1:0]           halfSeg,
  output logic                 minusSeg
);

  localparam int SEG_W = 7 * NUM_DIG;
  localparam logic [READ_W-1:0] MAX_V  = READ_W'(MAX_READING);
  localparam logic [READ_W-1:0] HALF_V = READ_W'(10 ** NUM_DIG);

  logic [READ_W-1:0] pendRead, showRead;
  logic              pendNeg, pendOver, pendFull;
  logic              showNeg, showOver;

  // Capture on strobe; hand over at the start of a backplane period.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendRead <= '0;
      pendNeg  <= 1'b0;
      pendOver <= 1'b0;
      pendFull <= 1'b0;
      showRead <= '0;
      showNeg  <= 1'b0;
      showOver <= 1'b0;
    end else begin
      if (strobe.frameStart && pendFull) begin
        showRead <= pendRead;
        showNeg  <= pendNeg;
        showOver <= pendOver;
      end
      if (resultValid) begin
        pendRead <= readingIn;
        pendNeg  <= negIn;
        pendOver <= overIn;
        pendFull <= 1'b1;
      end else if (strobe.frameStart) begin
        pendFull <= 1'b0;
      end
    end
  end

  logic             overEff;
  logic             halfLit;
  logic [SEG_W-1:0] litVec;

  assign overEff = showOver | (showRead > MAX_V);
  assign halfLit = overEff | (showRead >= HALF_V);

  genvar k;
  generate
    for (k = 0; k < NUM_DIG; k++) begin : g_digit
      localparam int DIV = 10 ** k;
      logic [3:0] digitVal;
      assign digitVal = 4'((32'(showRead) / DIV) % 10);
      assign litVec[7*k +: 7] = overEff ? 7'h00 : segPattern(digitVal);
    end
  endgenerate

  always_comb begin
    if (lampTest) begin
      segOut   = '1;
      halfSeg  = 2'b11;
      minusSeg = 1'b1;
    end else begin
      segOut   = litVec ^ {SEG_W{backplane}};
      halfSeg  = {2{halfLit ^ backplane}};
      minusSeg = showNeg ^ backplane;
    end
  end

endmodule

// File: rtl/lcd_static_drv.sv
module lcd_static_drv
  import lcd_pkg::*;
#(
  parameter int HALF_PERIOD = 100,
  parameter int READ_W      = 11,
  parameter int NUM_DIG     = 3,
  parameter int MAX_READING = 1999
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 resultValid,
  input  logic [READ_W-1:0]    readingIn,
  input  logic                 negIn,
  input  logic                 overIn,
  input  logic                 lampTest,
  output logic                 backplane,
  output logic [7*NUM_DIG-1:0] segOut,
  output logic [1:0]           halfSeg,
  output logic                 minusSeg
);

  lcdStrobe_t strobe;

  lcd_bp_ctrl #(.HALF_PERIOD(HALF_PERIOD)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .backplane (backplane),
    .strobe    (strobe)
  );

  lcd_seg_path #(
    .READ_W      (READ_W),
    .NUM_DIG     (NUM_DIG),
    .MAX_READING (MAX_READING)
  ) i_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .backplane   (backplane),
    .resultValid (resultValid),
    .readingIn   (readingIn),
    .negIn       (negIn),
    .overIn      (overIn),
    .lampTest    (lampTest),
    .segOut      (segOut),
    .halfSeg     (halfSeg),
    .minusSeg    (minusSeg)
  );

endmodule

// File: rtl/lcd_static_drv_chk.sv
module lcd_static_drv_chk #(
  parameter int HALF_PERIOD = 100,
  parameter int SEG_W       = 21
) (
  input logic             clk,
  input logic             rstN,
  input logic             lampTest,
  input logic             backplane,
  input logic [SEG_W-1:0] segOut,
  input logic [1:0]       halfSeg,
  input logic             minusSeg
);

  localparam int CNT_W = $clog2(HALF_PERIOD + 1);
  logic [CNT_W-1:0] cycCnt;
  logic [SEG_W+2:0] allSeg;

  assign allSeg = {segOut, halfSeg, minusSeg};

  always_ff @(posedge clk) begin
    if (!rstN) cycCnt <= '0;
    else if (cycCnt == CNT_W'(HALF_PERIOD - 1)) cycCnt <= '0;
    else cycCnt <= cycCnt + 1'b1;
  end

  // R1: toggle exactly when the independent cycle count reaches its end
  p_bp_flip_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cycCnt == CNT_W'(HALF_PERIOD - 1)) |=> (backplane != $past(backplane)));

  p_bp_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cycCnt != CNT_W'(HALF_PERIOD - 1)) |=> $stable(backplane));

  // R3: a rising mid-period edge inverts every segment line
  p_mid_invert_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!lampTest && $past(!lampTest) && $rose(backplane)) |-> (allSeg == ~$past(allSeg)));

  // R3: no segment change while the backplane holds
  p_no_glitch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!lampTest && $past(!lampTest) && $stable(backplane)) |-> $stable(allSeg));

  // R5: the two half-digit lines move together
  p_half_pair_r5: assert property (@(posedge clk) disable iff (!rstN)
    halfSeg[0] == halfSeg[1]);

  // R8: lamp test gives constant-high lines
  p_lamp_on_r8: assert property (@(posedge clk) disable iff (!rstN)
    lampTest |-> (&allSeg));

endmodule

bind lcd_static_drv lcd_static_drv_chk #(
  .HALF_PERIOD (HALF_PERIOD),
  .SEG_W       (7 * NUM_DIG)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .lampTest  (lampTest),
  .backplane (backplane),
  .segOut    (segOut),
  .halfSeg   (halfSeg),
  .minusSeg  (minusSeg)
);

// File: tb/test_lcd_static_drv.sv
`timescale 1ns/1ps
module test_lcd_static_drv;

  localparam int HALF = 100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resultValid = 1'b0;
  logic [10:0] readingIn = '0;
  logic        negIn = 1'b0;
  logic        overIn = 1'b0;
  logic        lampTest = 1'b0;
  logic        backplane;
  logic [20:0] segOut;
  logic [1:0]  halfSeg;
  logic        minusSeg;

  int    vecCnt = 0;
  int    errCnt = 0;
  string phase = "R10 reset";
  bit    done = 1'b0;

  always #10 clk = ~clk;

  lcd_static_drv i_lcd_static_drv (
    .clk(clk), .rstN(rstN), .resultValid(resultValid), .readingIn(readingIn),
    .negIn(negIn), .overIn(overIn), .lampTest(lampTest), .backplane(backplane),
    .segOut(segOut), .halfSeg(halfSeg), .minusSeg(minusSeg)
  );

  // ---------------- behavioural model ----------------
  int mCnt, mBp;
  int pRead, pNeg, pOver, pFull;
  int sRead, sNeg, sOver;

  always @(posedge clk) begin
    bit edgeNow;
    if (!rstN) begin
      mCnt = 0; mBp = 0;
      pRead = 0; pNeg = 0; pOver = 0; pFull = 0;
      sRead = 0; sNeg = 0; sOver = 0;
    end else begin
      edgeNow = 1'b0;
      if (mCnt == HALF - 1) begin
        mCnt = 0;
        if (mBp == 1) edgeNow = 1'b1;
        mBp = 1 - mBp;
      end else mCnt++;
      if (edgeNow && pFull == 1) begin
        sRead = pRead; sNeg = pNeg; sOver = pOver;
      end
      if (resultValid) begin
        pRead = readingIn; pNeg = negIn; pOver = overIn; pFull = 1;
      end else if (edgeNow) pFull = 0;
    end
  end

  function automatic logic [6:0] digitLit(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; default: return 7'h6F;
    endcase
  endfunction

  task automatic compareAll();
    logic [20:0] eSeg;
    logic [1:0]  eHalf;
    logic        eMinus, eBp, ovr, hl;
    int          div;
    eBp = (mBp == 1);
    ovr = (sOver != 0) || (sRead > 1999);
    hl  = ovr || (sRead >= 1000);
    div = 1;
    for (int k = 0; k < 3; k++) begin
      eSeg[7*k +: 7] = ovr ? 7'h00 : digitLit((sRead / div) % 10);
      div = div * 10;
    end
    eSeg   = eSeg ^ {21{eBp}};
    eHalf  = {2{hl ^ eBp}};
    eMinus = (sNeg != 0) ^ eBp;
    if (lampTest) begin
      eSeg = '1; eHalf = 2'b11; eMinus = 1'b1;
    end
    vecCnt++;
    if (backplane !== eBp) begin
      errCnt++;
      $display("FAIL R1 [%s] backplane=%b expected %b", phase, backplane, eBp);
    end
    if (segOut !== eSeg) begin
      errCnt++;
      $display("FAIL %s digits segOut=%h expected %h", phase, segOut, eSeg);
    end
    if (halfSeg !== eHalf) begin
      errCnt++;
      $display("FAIL %s R5 halfSeg=%b expected %b", phase, halfSeg, eHalf);
    end
    if (minusSeg !== eMinus) begin
      errCnt++;
      $display("FAIL %s R7 minusSeg=%b expected %b", phase, minusSeg, eMinus);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rstN && !done) compareAll();
  end

  // ---------------- stimulus ----------------
  task automatic strobe(input int val, input bit neg, input bit ovr);
    @(negedge clk);
    readingIn = 11'(val); negIn = neg; overIn = ovr; resultValid = 1'b1;
    @(negedge clk);
    resultValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    phase = "R10 reset state"; idle(250);
    phase = "R4 R2 R3 reading 1234"; strobe(1234, 0, 0); idle(450);
    phase = "R5 reading 999"; strobe(999, 0, 0); idle(450);
    phase = "R5 reading 1000"; strobe(1000, 1, 0); idle(450);
    phase = "R7 R4 reading 1999 negative"; strobe(1999, 1, 0); idle(450);
    phase = "R4 reading 567"; strobe(567, 0, 0); idle(450);
    phase = "R6 overrange flag negative"; strobe(42, 1, 1); idle(450);
    phase = "R8 lamp test"; lampTest = 1'b1; idle(300);
    lampTest = 1'b0;
    phase = "R6 reading 2047 implicit overrange"; strobe(2047, 0, 0); idle(450);
    phase = "R9 two strobes in one period";
    strobe(321, 0, 0); idle(20); strobe(804, 1, 0); idle(450);
    phase = "R9 strobe on frame edge";
    do @(negedge clk); while (!(mCnt == HALF - 1 && mBp == 1));
    readingIn = 11'd76; negIn = 1'b0; overIn = 1'b0; resultValid = 1'b1;
    @(negedge clk); resultValid = 1'b0;
    idle(450);
    phase = "R8 lamp test over digits"; lampTest = 1'b1; idle(150);
    lampTest = 1'b0; idle(250);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      errCnt++;
      $display("FAIL watchdog [%s] actual hung expected finished", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

endmodule